// File: doc/BRIEF.md
# Relay Driver Short-Circuit Latch

This block supervises the enable of a wiper relay driver. The wiper sequencer asks for the relay through a plain request pin, and the block passes that request on to the driver. An analog overcurrent comparator and a load-dump detector report to the block only as digital flags. A 1 ms tick input paces the overcurrent debounce.

If the overcurrent flag stays high for a full debounce window, a fault is stored. The stored fault holds the relay off until the operator releases both the interval switch and the wash switch. If the short is still there when a switch is pressed again, the fault is stored again after a fresh window.

While the supply is in a load-dump condition, the relay is forced on so that the driver can absorb the surge. During that time, fault detection is blanked. Power-on reset turns the relay off and forgets any fault. Every pin is a plain level signal; the block has no streaming interface and applies no back-pressure.

Top module: `relay_guard`

## Requirements
- R1: `fault_latched` rises only after `oc_flag` has been high on every clock while `ms_tick` pulsed `TRIP_TICKS` times (default 10). The fault is stored on the clock edge that takes the 10th tick and is visible from the next cycle.
- R2: A single low cycle of `oc_flag` discards the count gathered so far. A burst that covers only 9 ticks never stores a fault.
- R3: While a fault is stored and `ldump_flag` is low, `relay_en` is 0 whatever `relay_req` is.
- R4: Switch inputs are 1 for closed and 0 for open. A stored fault stays stored while either switch is closed. It clears on the first clock edge where both switches are open, and the debounce count is held at zero for as long as both are open.
- R5: After a fault clears, if the overcurrent persists and a switch closes again, the fault is stored again after a fresh count of 10 ticks.
- R6: While `ldump_flag` is 1, `relay_en` is 1, the debounce count is held at zero and no new fault is stored. When the flag falls, counting starts again from zero.
- R7: While `rst_n` is low, `relay_en` is 0 and the stored fault and the count are cleared.
- R8: With no fault stored, no load-dump and reset released, `relay_en` equals `relay_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| relay_req | input | 1 | Relay request from the wiper sequencer |
| oc_flag | input | 1 | Output overcurrent comparator flag |
| ldump_flag | input | 1 | Load-dump detector flag |
| sw_int_on | input | 1 | Interval switch closed (debounced) |
| sw_wash_on | input | 1 | Wash switch closed (debounced) |
| relay_en | output | 1 | Relay driver enable |
| fault_latched | output | 1 | Stored short-circuit fault |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that `ms_tick` is a single-cycle pulse rather than a level. The bench drives every input on the falling clock edge. It raises the tick for one cycle in every four, so each debounce window spans 40 clocks, and its windows always start on a tick boundary. The overcurrent, load-dump and switch flags change only between windows, which keeps the expected latch cycle exact.

// File: rtl/relay_guard_pkg.sv
package relay_guard_pkg;
  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_REQ   = 2'd1,
    DRV_FORCE = 2'd2
  } drive_src_e;
endpackage

// File: rtl/rg_oc_debounce.sv
module rg_oc_debounce #(
  parameter int TRIP_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic oc_flag,
  input  logic blank,
  output logic trip
);
  localparam int CNT_W = $clog2(TRIP_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_TICKS - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(TRIP_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             armed;

  assign armed = oc_flag && !blank;
  assign trip  = armed && ms_tick && (cnt_q == LAST);

  // Saturating count of ticks seen with the flag held high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!armed) begin
      cnt_q <= '0;
    end else if (ms_tick && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rg_fault_store.sv
module rg_fault_store (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  // Clear wins over set: a release of both switches always empties the store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o <= 1'b0;
    end else if (clr_i) begin
      fault_o <= 1'b0;
    end else if (set_i) begin
      fault_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rg_drive_sel.sv
module rg_drive_sel
  import relay_guard_pkg::*;
(
  input  logic rst_n,
  input  logic ldump,
  input  logic fault,
  input  logic req,
  output logic drive
);
  drive_src_e src;

  always_comb begin
    if (!rst_n)      src = DRV_OFF;
    else if (ldump)  src = DRV_FORCE;
    else if (fault)  src = DRV_OFF;
    else             src = DRV_REQ;
  end

  always_comb begin
    unique case (src)
      DRV_FORCE: drive = 1'b1;
      DRV_REQ:   drive = req;
      default:   drive = 1'b0;
    endcase
  end
endmodule

// File: rtl/relay_guard.sv
module relay_guard #(
  parameter int TRIP_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic relay_req,
  input  logic oc_flag,
  input  logic ldump_flag,
  input  logic sw_int_on,
  input  logic sw_wash_on,
  output logic relay_en,
  output logic fault_latched
);
  logic both_open;
  logic blank;
  logic trip;

  assign both_open = !sw_int_on && !sw_wash_on;
  assign blank     = ldump_flag || both_open;

  rg_oc_debounce #(.TRIP_TICKS(TRIP_TICKS)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .oc_flag (oc_flag),
    .blank   (blank),
    .trip    (trip)
  );

  rg_fault_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (trip),
    .clr_i   (both_open),
    .fault_o (fault_latched)
  );

  rg_drive_sel u_drv (
    .rst_n (rst_n),
    .ldump (ldump_flag),
    .fault (fault_latched),
    .req   (relay_req),
    .drive (relay_en)
  );
endmodule

// File: rtl/relay_guard_chk.sv
module relay_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic relay_req,
  input logic oc_flag,
  input logic ldump_flag,
  input logic sw_int_on,
  input logic sw_wash_on,
  input logic relay_en,
  input logic fault_latched
);
  a_r1_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> ($past(oc_flag) && $past(ms_tick)));

  a_r3_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !ldump_flag) |-> !relay_en);

  a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_int_on && !sw_wash_on) |=> !fault_latched);

  a_r4_hold_while_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && (sw_int_on || sw_wash_on)) |=> fault_latched);

  a_r6_ldump_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
    ldump_flag |-> relay_en);

  a_r6_no_set_in_ldump: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> !$past(ldump_flag));

  a_r8_follow_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_latched && !ldump_flag) |-> (relay_en == relay_req));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset_off: assert (!relay_en && !fault_latched);
    end
  end
endmodule

bind relay_guard relay_guard_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ms_tick       (ms_tick),
  .relay_req     (relay_req),
  .oc_flag       (oc_flag),
  .ldump_flag    (ldump_flag),
  .sw_int_on     (sw_int_on),
  .sw_wash_on    (sw_wash_on),
  .relay_en      (relay_en),
  .fault_latched (fault_latched)
);

// File: tb/relay_guard_bench.sv
module relay_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic relay_req = 1'b0;
  logic oc_flag = 1'b0;
  logic ldump_flag = 1'b0;
  logic sw_int_on = 1'b0;
  logic sw_wash_on = 1'b0;
  logic relay_en;
  logic fault_latched;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_ticks = 0;
  bit m_fault = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  relay_guard u_relay_guard (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .relay_req(relay_req),
    .oc_flag(oc_flag), .ldump_flag(ldump_flag), .sw_int_on(sw_int_on),
    .sw_wash_on(sw_wash_on), .relay_en(relay_en), .fault_latched(fault_latched)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks <= 0;
      m_fault <= 1'b0;
    end else begin
      bit open_both;
      open_both = !sw_int_on && !sw_wash_on;
      if (ldump_flag || !oc_flag || open_both) m_ticks <= 0;
      else if (ms_tick && m_ticks < 10) m_ticks <= m_ticks + 1;
      if (open_both) m_fault <= 1'b0;
      else if (!ldump_flag && oc_flag && ms_tick && m_ticks == 9) m_fault <= 1'b1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_model();
    logic exp_en;
    string tag;
    if (!rst_n)          begin exp_en = 1'b0; tag = "R7 relay_en"; end
    else if (ldump_flag) begin exp_en = 1'b1; tag = "R6 relay_en"; end
    else if (m_fault)    begin exp_en = 1'b0; tag = "R3 relay_en"; end
    else                 begin exp_en = relay_req; tag = "R8 relay_en"; end
    check(tag, relay_en, exp_en);
    check("R1 fault_latched vs model", fault_latched, m_fault);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ms_tick = (cyc % 4 == 0);
      if (cyc % 3 == 0) relay_req = ~relay_req;
      cyc++;
      #1;
      compare_model();
    end
  endtask

  initial begin
    sw_int_on = 1'b1;
    relay_req = 1'b1;
    run(4);
    check("R7 reset holds relay off", relay_en, 1'b0);
    check("R7 reset clears fault", fault_latched, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    run(12);                                   // R8 follow request
    oc_flag = 1'b1;
    run(36);
    check("R2 nine ticks do not trip", fault_latched, 1'b0);
    oc_flag = 1'b0;
    run(4);
    oc_flag = 1'b1;
    run(36);
    check("R2 count restarted after gap", fault_latched, 1'b0);
    run(4);
    check("R1 trip after ten ticks", fault_latched, 1'b1);
    relay_req = 1'b1;
    #1;
    check("R3 fault blocks request", relay_en, 1'b0);
    oc_flag = 1'b0;
    sw_int_on = 1'b0;
    sw_wash_on = 1'b1;
    run(8);
    check("R4 fault held with wash closed", fault_latched, 1'b1);
    sw_wash_on = 1'b0;
    oc_flag = 1'b1;
    run(4);
    check("R4 cleared with both open", fault_latched, 1'b0);
    run(40);
    check("R4 no count while both open", fault_latched, 1'b0);
    sw_int_on = 1'b1;
    run(36);
    check("R5 not yet re-tripped", fault_latched, 1'b0);
    run(4);
    check("R5 re-trip after fresh window", fault_latched, 1'b1);
    ldump_flag = 1'b1;
    #1;
    check("R6 load-dump forces on over fault", relay_en, 1'b1);
    sw_int_on = 1'b0;
    run(4);
    sw_int_on = 1'b1;
    run(80);
    check("R6 no trip during load-dump", fault_latched, 1'b0);
    check("R6 relay forced on", relay_en, 1'b1);
    ldump_flag = 1'b0;
    run(36);
    check("R6 count restarts after load-dump", fault_latched, 1'b0);
    run(4);
    check("R6 trip after load-dump ends", fault_latched, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 reset clears stored fault", fault_latched, 1'b0);
    check("R7 reset turns relay off", relay_en, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule